// File: doc/BRIEF.md
# Interrupt-Driven Register Page Stack

This block keeps the page number that selects which bank of special-function registers a small microcontroller core sees. The page lives in the top entry of a short hardware stack. When the interrupt controller signals entry into a service routine, the block pushes the running page down one level and loads the page that belongs to that interrupt source. When the routine returns, the stack pops and the interrupted code finds its page as it left it. A default depth of three holds main-line code, one low-priority level and one nested high-priority level.

Software can write and read every stack entry. A one-bit control register turns automatic switching on or off. When switching is off, the entry and return strobes are ignored. The block also decodes register addresses for the core. Addresses in a configurable global group respond on any page. Every other address responds only when the current page equals the page assigned to that register.

Top module: `pgstk_top`

## Requirements
- R1: During and after reset, every stack entry reads 0x00 and the automatic-switching enable (`auto_en`) reads 1.
- R2: With `auto_en` = 1, an `int_push` pulse shifts every entry one level deeper in one clock: entry i+1 takes entry i, and entry 0 loads `int_page`. The oldest entry's old value is discarded. `cur_page` shows the new entry 0 after that edge.
- R3: With `auto_en` = 1 and no push, an `int_pop` pulse shifts every entry one level up: entry i takes entry i+1. The deepest entry keeps its value.
- R4: With `auto_en` = 0, `int_push` and `int_pop` leave every entry unchanged. Only software writes alter the stack.
- R5: A write with `wr_en` = 1 and `wr_sel` = i (i < DEPTH) loads `wr_data` into entry i. `wr_sel` = DEPTH writes `wr_data[0]` into `auto_en`. All entries read back on `stack_rd`, with entry i at bits [i*PAGE_W +: PAGE_W].
- R6: When an automatic push or pop happens in the same cycle as a software write to a stack entry, the shift wins and the write is dropped.
- R7: When `int_push` and `int_pop` arrive together with `auto_en` = 1, only the push is performed.
- R8: An address with (`dec_addr` & 0x8F) == 0x80, such as the port registers at 0x80, 0x90, 0xA0 and 0xB0, raises `dec_global`. It also raises `dec_hit` whatever the current page.
- R9: Any other address raises `dec_hit` only when `dec_page` equals `cur_page`. For example, 0xA3 assigned to page 0x00 hits on page 0x00 and misses on page 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Software register write strobe |
| wr_sel | input | 2 | Write target: 0..DEPTH-1 selects a stack entry, DEPTH selects the control bit |
| wr_data | input | 8 | Write data |
| int_push | input | 1 | Interrupt-entry strobe |
| int_page | input | 8 | Page of the interrupt being entered |
| int_pop | input | 1 | Interrupt-return strobe |
| cur_page | output | 8 | Effective page, equal to entry 0 |
| stack_rd | output | 24 | All stack entries, entry 0 in the low byte |
| auto_en | output | 1 | Automatic-switching enable |
| dec_addr | input | 8 | Register address being decoded |
| dec_page | input | 8 | Page assigned to that register |
| dec_global | output | 1 | Address belongs to the every-page group |
| dec_hit | output | 1 | Register is visible on the current page |

## Verification
The assertions assume that `int_push` and `int_pop` are single-cycle strobes sampled on the clock edge, and that no strobe or write is trusted in the cycle in which reset is released. The checker arms itself one cycle after reset for this reason. The decode checks assume that `dec_addr` and `dec_page` are stable while being sampled. The bench drives all inputs on the falling edge, so every strobe and address is stable across the rising edge. Its random stimulus sets push and pop in the same cycle, writes during shifts, and flips the enable at a low rate, so every case in the rules is reached.

// File: rtl/pgstk_pkg.sv
package pgstk_pkg;
   typedef enum logic [1:0] {
      STK_HOLD = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2
   } stk_op_e;
endpackage

// File: rtl/pgstk_ctrl.sv
module pgstk_ctrl
   import pgstk_pkg::*;
#(
   parameter int SEL_W    = 2,
   parameter int CTRL_IDX = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic             wr_bit,
   input  logic             push,
   input  logic             pop,
   output logic             auto_en,
   output stk_op_e          op
);
   logic en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= 1'b1;
      else if (wr_en && (wr_sel == SEL_W'(CTRL_IDX)))
         en_q <= wr_bit;
   end

   // push outranks pop; both are void while switching is off
   always_comb begin
      if (!en_q)      op = STK_HOLD;
      else if (push)  op = STK_PUSH;
      else if (pop)   op = STK_POP;
      else            op = STK_HOLD;
   end

   assign auto_en = en_q;
endmodule

// File: rtl/pgstk_entries.sv
module pgstk_entries
   import pgstk_pkg::*;
#(
   parameter int PAGE_W = 8,
   parameter int DEPTH  = 3,
   parameter int SEL_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  stk_op_e                 op,
   input  logic [PAGE_W-1:0]       int_page,
   input  logic                    wr_en,
   input  logic [SEL_W-1:0]        wr_sel,
   input  logic [PAGE_W-1:0]       wr_data,
   output logic [DEPTH*PAGE_W-1:0] flat
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [PAGE_W-1:0] q;
      logic [PAGE_W-1:0] from_above;
      logic [PAGE_W-1:0] from_below;
      logic              sw_hit;

      if (i == 0) begin : g_top
         assign from_above = int_page;
      end else begin : g_mid
         assign from_above = flat[(i-1)*PAGE_W +: PAGE_W];
      end

      if (i == DEPTH-1) begin : g_last
         assign from_below = q;
      end else begin : g_inner
         assign from_below = flat[(i+1)*PAGE_W +: PAGE_W];
      end

      assign sw_hit = wr_en && (wr_sel == SEL_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else begin
            case (op)
               STK_PUSH: q <= from_above;
               STK_POP:  q <= from_below;
               default:  if (sw_hit) q <= wr_data;
            endcase
         end
      end

      assign flat[i*PAGE_W +: PAGE_W] = q;
   end
endmodule

// File: rtl/pgstk_decode.sv
module pgstk_decode #(
   parameter int                ADDR_W   = 8,
   parameter int                PAGE_W   = 8,
   parameter logic [ADDR_W-1:0] GLB_MASK = 8'h8F,
   parameter logic [ADDR_W-1:0] GLB_VAL  = 8'h80
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [PAGE_W-1:0] reg_page,
   input  logic [PAGE_W-1:0] cur,
   output logic              global_o,
   output logic              hit_o
);
   assign global_o = ((addr & GLB_MASK) == GLB_VAL);
   assign hit_o    = global_o || (reg_page == cur);
endmodule

// File: rtl/pgstk_top.sv
module pgstk_top
   import pgstk_pkg::*;
#(
   parameter int                PAGE_W   = 8,
   parameter int                DEPTH    = 3,
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] GLB_MASK = 8'h8F,
   parameter logic [ADDR_W-1:0] GLB_VAL  = 8'h80,
   localparam int               SEL_W    = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [SEL_W-1:0]        wr_sel,
   input  logic [PAGE_W-1:0]       wr_data,
   input  logic                    int_push,
   input  logic [PAGE_W-1:0]       int_page,
   input  logic                    int_pop,
   output logic [PAGE_W-1:0]       cur_page,
   output logic [DEPTH*PAGE_W-1:0] stack_rd,
   output logic                    auto_en,
   input  logic [ADDR_W-1:0]       dec_addr,
   input  logic [PAGE_W-1:0]       dec_page,
   output logic                    dec_global,
   output logic                    dec_hit
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("pgstk_top: DEPTH must be at least 2");
   end
   if (PAGE_W < 1) begin : g_bad_width
      $error("pgstk_top: PAGE_W must be at least 1");
   end
   if ((GLB_VAL & ~GLB_MASK) != '0) begin : g_bad_glb
      $error("pgstk_top: GLB_VAL has bits outside GLB_MASK");
   end

   stk_op_e op;

   pgstk_ctrl #(.SEL_W(SEL_W), .CTRL_IDX(DEPTH)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_bit  (wr_data[0]),
      .push    (int_push),
      .pop     (int_pop),
      .auto_en (auto_en),
      .op      (op)
   );

   pgstk_entries #(.PAGE_W(PAGE_W), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .int_page (int_page),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .flat     (stack_rd)
   );

   assign cur_page = stack_rd[PAGE_W-1:0];

   pgstk_decode #(
      .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .GLB_MASK(GLB_MASK), .GLB_VAL(GLB_VAL)
   ) u_dec (
      .addr     (dec_addr),
      .reg_page (dec_page),
      .cur      (cur_page),
      .global_o (dec_global),
      .hit_o    (dec_hit)
   );
endmodule

// File: rtl/pgstk_chk.sv
module pgstk_chk #(
   parameter int PAGE_W = 8,
   parameter int DEPTH  = 3,
   parameter int ADDR_W = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic                    int_push,
   input logic [PAGE_W-1:0]       int_page,
   input logic                    int_pop,
   input logic [PAGE_W-1:0]       cur_page,
   input logic [DEPTH*PAGE_W-1:0] stack_rd,
   input logic                    auto_en,
   input logic [PAGE_W-1:0]       dec_page,
   input logic                    dec_global,
   input logic                    dec_hit
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |-> (stack_rd == '0) && auto_en);

   // R2
   push_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && auto_en && int_push |=>
         (cur_page == $past(int_page)) &&
         (stack_rd[PAGE_W +: PAGE_W] == $past(stack_rd[0 +: PAGE_W])));

   // R3
   pop_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && auto_en && !int_push && int_pop |=>
         (cur_page == $past(stack_rd[PAGE_W +: PAGE_W])) &&
         (stack_rd[(DEPTH-1)*PAGE_W +: PAGE_W] ==
          $past(stack_rd[(DEPTH-1)*PAGE_W +: PAGE_W])));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !auto_en && !wr_en |=> $stable(stack_rd));

   // R8
   global_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_global |-> dec_hit);

   // R9
   page_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit && !dec_global |-> dec_page == cur_page);
endmodule

bind pgstk_top pgstk_chk #(.PAGE_W(PAGE_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .int_push   (int_push),
   .int_page   (int_page),
   .int_pop    (int_pop),
   .cur_page   (cur_page),
   .stack_rd   (stack_rd),
   .auto_en    (auto_en),
   .dec_page   (dec_page),
   .dec_global (dec_global),
   .dec_hit    (dec_hit)
);

// File: tb/sim_pgstk_top.sv
module sim_pgstk_top;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = '0;
   logic [7:0] wr_data = '0;
   logic       int_push = 1'b0;
   logic [7:0] int_page = '0;
   logic       int_pop = 1'b0;
   logic [7:0] cur_page;
   logic [23:0] stack_rd;
   logic       auto_en;
   logic [7:0] dec_addr = '0;
   logic [7:0] dec_page = '0;
   logic       dec_global;
   logic       dec_hit;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] m [3];
   logic       m_auto;

   always #(CLK_P/2) clk = ~clk;

   pgstk_top u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .int_push(int_push), .int_page(int_page), .int_pop(int_pop),
      .cur_page(cur_page), .stack_rd(stack_rd), .auto_en(auto_en),
      .dec_addr(dec_addr), .dec_page(dec_page),
      .dec_global(dec_global), .dec_hit(dec_hit)
   );

   function automatic bit is_glb(input logic [7:0] a);
      return (a & 8'h8F) == 8'h80;
   endfunction

   function automatic logic [23:0] pack_model();
      return {m[2], m[1], m[0]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_state(input string tag);
      chk(tag, {8'h0, stack_rd}, {8'h0, pack_model()});
      chk(tag, {31'h0, auto_en}, {31'h0, m_auto});
      chk(tag, {24'h0, cur_page}, {24'h0, m[0]});
   endtask

   // one clock: inputs applied at falling edge, decode checked, model stepped, state checked
   task automatic cyc(input bit we, input logic [1:0] sel, input logic [7:0] d,
                      input bit ps, input logic [7:0] pg, input bit pp,
                      input logic [7:0] da, input logic [7:0] dp);
      string tag;
      wr_en = we; wr_sel = sel; wr_data = d;
      int_push = ps; int_page = pg; int_pop = pp;
      dec_addr = da; dec_page = dp;
      #1;
      chk("R8", {31'h0, dec_global}, {31'h0, is_glb(da)});
      chk(is_glb(da) ? "R8" : "R9", {31'h0, dec_hit},
          {31'h0, is_glb(da) || (dp == m[0])});
      if (m_auto && ps) begin
         tag = (pp ? "R7" : (we && sel != 2'd3) ? "R6" : "R2");
         m[2] = m[1]; m[1] = m[0]; m[0] = pg;
      end else if (m_auto && pp) begin
         tag = (we && sel != 2'd3) ? "R6" : "R3";
         m[0] = m[1]; m[1] = m[2];
      end else begin
         tag = (!m_auto && (ps || pp)) ? "R4" : "R5";
         if (we && sel != 2'd3) m[sel] = d;
      end
      if (we && sel == 2'd3) m_auto = d[0];
      @(negedge clk);
      check_state(tag);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      #1 rst_n = 1'b0;
      m[0] = '0; m[1] = '0; m[2] = '0; m_auto = 1'b1;
      @(negedge clk); @(negedge clk);
      check_state("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1");

      // R5 direct writes to each entry, readback
      cyc(1, 2'd0, 8'h11, 0, 8'h00, 0, 8'h00, 8'h00);
      cyc(1, 2'd1, 8'h22, 0, 8'h00, 0, 8'h00, 8'h00);
      cyc(1, 2'd2, 8'h33, 0, 8'h00, 0, 8'h00, 8'h00);
      // R2 nested pushes, R3 pops with oldest held
      cyc(0, 2'd0, 8'h00, 1, 8'h0A, 0, 8'h00, 8'h00);
      cyc(0, 2'd0, 8'h00, 1, 8'h0B, 0, 8'h00, 8'h00);
      cyc(0, 2'd0, 8'h00, 0, 8'h00, 1, 8'h00, 8'h00);
      cyc(0, 2'd0, 8'h00, 0, 8'h00, 1, 8'h00, 8'h00);
      // R6 push beats a write to current
      cyc(1, 2'd0, 8'h77, 1, 8'h05, 0, 8'h00, 8'h00);
      // R7 push beats pop
      cyc(0, 2'd0, 8'h00, 1, 8'h06, 1, 8'h00, 8'h00);
      // R4 disable, strobes ignored, write still works
      cyc(1, 2'd3, 8'h00, 0, 8'h00, 0, 8'h00, 8'h00);
      cyc(0, 2'd0, 8'h00, 1, 8'h44, 0, 8'h00, 8'h00);
      cyc(0, 2'd0, 8'h00, 0, 8'h00, 1, 8'h00, 8'h00);
      cyc(1, 2'd0, 8'h00, 1, 8'h55, 0, 8'hA3, 8'h00);
      // R9 0xA3 on page 0 hits, on page 1 misses; R8 0x90 on any page
      cyc(0, 2'd0, 8'h00, 0, 8'h00, 0, 8'hA3, 8'h00);
      cyc(0, 2'd0, 8'h00, 0, 8'h00, 0, 8'hA3, 8'h01);
      cyc(1, 2'd0, 8'h05, 0, 8'h00, 0, 8'h90, 8'h3C);
      cyc(0, 2'd0, 8'h00, 0, 8'h00, 0, 8'h80, 8'h00);
      cyc(1, 2'd3, 8'h01, 0, 8'h00, 0, 8'hA3, 8'h05);

      for (int n = 0; n < 3000; n++) begin
         logic [7:0] ra, rp;
         bit we;
         logic [1:0] sel;
         ra = 8'($urandom);
         rp = ($urandom_range(0, 1) != 0) ? m[0] : 8'($urandom_range(0, 7));
         we  = ($urandom_range(0, 3) == 0);
         sel = 2'($urandom);
         if (sel == 2'd3 && $urandom_range(0, 3) != 0) sel = 2'd0;
         cyc(we, sel, 8'($urandom), $urandom_range(0, 2) == 0,
             8'($urandom_range(0, 15)), $urandom_range(0, 2) == 0, ra, rp);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule